// File: doc/BRIEF.md
# Stop Mode Entry and Wake Controller

This block decides when a processor core drops into its clock-stopped low-power state and when it comes back out. A stop request from the core is honoured only when the core's stop-disable bit is clear. Otherwise the request is flagged as a no-operation and the core keeps running. While stopped, a single clock-enable output is held low. That output gates the oscillator and every internal clock, so all peripherals freeze.

Wake sources are the active-low maskable interrupt pin, the active-low non-maskable interrupt pin, a latched pending edge interrupt and the active-low reset pin. They are sampled through a two-stage synchronizer on a sampling clock that is never gated. When a wake is seen, the block holds the clock enable low for a programmable settling interval. It then raises the enable and, in the same cycle, presents a one-cycle wake cause. The cause tells the core to run a maskable handler, run a non-maskable handler, continue with the next instruction, or perform a normal reset sequence.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset, clk_en is 1 and both cause_valid and nop_o are 0.
- R2: While running, stop_req with stop_dis at 0 drives clk_en to 0 from the next cycle on. clk_en only ever falls after such a request.
- R3: While running, stop_req with stop_dis at 1 raises nop_o in the same cycle, and clk_en stays 1.
- R4: A wake pin change reaches the controller after two synchronizer stages. clk_en then stays 0 for SETTLE_CYC further cycles, so cause_valid appears SETTLE_CYC+3 clock edges after the pin changes.
- R5: A low maskable interrupt pin does not end stop while irq_mask is 1.
- R6: A low maskable interrupt pin with irq_mask at 0 ends stop with cause code 0 (service maskable interrupt).
- R7: A pending edge interrupt ends stop with cause code 0 when irq_mask is 0 and is ignored when irq_mask is 1.
- R8: A low non-maskable pin ends stop whatever nmi_mask holds. The cause is code 1 (service non-maskable interrupt) when nmi_mask is 0 and code 2 (continue in line) when nmi_mask is 1.
- R9: A low reset pin ends stop with cause code 3 (reset). Reset outranks the non-maskable pin, and the non-maskable pin outranks maskable sources.
- R10: cause_valid lasts exactly one cycle and coincides with clk_en returning to 1, after which the controller is running again.
- R11: stop_req has no effect while stopped: nop_o stays 0 and clk_en stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock, never gated |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | One-cycle stop instruction strobe from the core |
| stop_dis | input | 1 | Stop-disable bit; 1 turns stop into a no-op |
| irq_mask | input | 1 | Maskable interrupt mask bit |
| nmi_mask | input | 1 | Non-maskable interrupt mask bit (selects resume path) |
| irq_n | input | 1 | Active-low maskable interrupt pin, asynchronous |
| nmi_n | input | 1 | Active-low non-maskable interrupt pin, asynchronous |
| edge_pend | input | 1 | Latched pending edge-triggered maskable interrupt |
| rst_pin_n | input | 1 | Active-low reset pin, asynchronous |
| clk_en | output | 1 | Clock and oscillator enable; 0 while stopped or settling |
| nop_o | output | 1 | Stop request treated as no-operation |
| cause_valid | output | 1 | One-cycle strobe qualifying cause |
| cause | output | 2 | Wake cause: 0 maskable, 1 non-maskable, 2 continue, 3 reset |

## Verification
The hardest case to reach is a maskable source that is active but masked. A stop must be entered, the masked level or edge held long enough to prove no wake follows, and the stop then ended by another source whose priority against the still-active masked source is itself checked. The stimulus enters stop and holds the masked input over many cycles while clk_en is watched. It then asserts the non-maskable or reset pin on top, so the scoreboard sees exactly one cause, with the expected code and latency. Simultaneous assertion of all pins covers the priority order.

// File: rtl/swc_pkg.sv
package swc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_REPORT = 2'd3
    } swc_state_e;

    typedef enum logic [1:0] {
        WK_IRQ   = 2'b00,
        WK_NMI   = 2'b01,
        WK_CONT  = 2'b10,
        WK_RESET = 2'b11
    } wake_cause_e;

    typedef struct packed {
        logic rst_low;
        logic nmi_low;
        logic irq_low;
        logic edge_pend;
    } wake_src_t;

    typedef struct packed {
        logic        hit;
        wake_cause_e cause;
    } wake_dec_t;

    // Priority: reset pin, then non-maskable pin, then maskable sources.
    function automatic wake_dec_t resolve_wake(wake_src_t s, logic irq_mask, logic nmi_mask);
        wake_dec_t d;
        d.hit   = 1'b0;
        d.cause = WK_IRQ;
        if (s.rst_low) begin
            d.hit   = 1'b1;
            d.cause = WK_RESET;
        end else if (s.nmi_low) begin
            d.hit   = 1'b1;
            d.cause = nmi_mask ? WK_CONT : WK_NMI;
        end else if ((s.irq_low || s.edge_pend) && !irq_mask) begin
            d.hit   = 1'b1;
            d.cause = WK_IRQ;
        end
        return d;
    endfunction

endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;
endmodule

// File: rtl/swc_settle_timer.sv
module swc_settle_timer #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = run && (cnt_q == CW'(SETTLE_CYC - 1));
endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
    import swc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stop_req,
    input  logic        stop_dis,
    input  wake_dec_t   dec,
    input  logic        settle_last,
    output logic        settle_run,
    output logic        clk_en,
    output logic        nop_o,
    output logic        cause_valid,
    output wake_cause_e cause
);
    swc_state_e  state_q, state_d;
    wake_cause_e cause_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (stop_req && !stop_dis) state_d = ST_STOP;
            ST_STOP:   if (dec.hit)               state_d = ST_SETTLE;
            ST_SETTLE: if (settle_last)           state_d = ST_REPORT;
            ST_REPORT:                            state_d = ST_RUN;
            default:                              state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            cause_q <= WK_IRQ;
        end else begin
            state_q <= state_d;
            if (state_q == ST_STOP && dec.hit) begin
                cause_q <= dec.cause;
            end
        end
    end

    assign settle_run  = (state_q == ST_SETTLE);
    assign clk_en      = (state_q == ST_RUN) || (state_q == ST_REPORT);
    assign nop_o       = (state_q == ST_RUN) && stop_req && stop_dis;
    assign cause_valid = (state_q == ST_REPORT);
    assign cause       = cause_q;
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import swc_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic       stop_dis,
    input  logic       irq_mask,
    input  logic       nmi_mask,
    input  logic       irq_n,
    input  logic       nmi_n,
    input  logic       edge_pend,
    input  logic       rst_pin_n,
    output logic       clk_en,
    output logic       nop_o,
    output logic       cause_valid,
    output logic [1:0] cause
);
    localparam int          NSRC     = 4;
    localparam logic [NSRC-1:0] SYNC_IDLE = 4'b1110;

    logic [NSRC-1:0] raw_pins;
    logic [NSRC-1:0] sync_pins;
    wake_src_t       src;
    wake_dec_t       dec;
    logic            settle_run;
    logic            settle_last;
    wake_cause_e     cause_e;

    assign raw_pins = {rst_pin_n, nmi_n, irq_n, edge_pend};

    swc_sync #(.W(NSRC), .RST_VAL(SYNC_IDLE)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_pins),
        .dout (sync_pins)
    );

    always_comb begin
        src.rst_low   = ~sync_pins[3];
        src.nmi_low   = ~sync_pins[2];
        src.irq_low   = ~sync_pins[1];
        src.edge_pend =  sync_pins[0];
        dec           = resolve_wake(src, irq_mask, nmi_mask);
    end

    swc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .run  (settle_run),
        .last (settle_last)
    );

    swc_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .stop_req    (stop_req),
        .stop_dis    (stop_dis),
        .dec         (dec),
        .settle_last (settle_last),
        .settle_run  (settle_run),
        .clk_en      (clk_en),
        .nop_o       (nop_o),
        .cause_valid (cause_valid),
        .cause       (cause_e)
    );

    assign cause = cause_e;
endmodule

// File: rtl/swc_chk.sv
module swc_chk (
    input logic clk,
    input logic rst,
    input logic stop_req,
    input logic stop_dis,
    input logic clk_en,
    input logic nop_o,
    input logic cause_valid
);
    // R2
    entry_clk_off_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !cause_valid && stop_req && !stop_dis) |=> !clk_en);

    // R2
    fall_only_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_en) |-> $past(stop_req && !stop_dis));

    // R3
    nop_keeps_run_chk: assert property (@(posedge clk) disable iff (rst)
        nop_o |=> clk_en);

    // R10
    report_single_chk: assert property (@(posedge clk) disable iff (rst)
        cause_valid |=> !cause_valid);

    // R10
    reawake_with_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en) |-> cause_valid);

    // R11
    no_nop_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_en |-> !nop_o);
endmodule

bind stop_wake_ctrl swc_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .stop_req    (stop_req),
    .stop_dis    (stop_dis),
    .clk_en      (clk_en),
    .nop_o       (nop_o),
    .cause_valid (cause_valid)
);

// File: tb/stop_wake_ctrl_tb_top.sv
module stop_wake_ctrl_tb_top;
    localparam int SETTLE = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req = 1'b0, stop_dis = 1'b0, irq_mask = 1'b1, nmi_mask = 1'b1;
    logic irq_n = 1'b1, nmi_n = 1'b1, edge_pend = 1'b0, rst_pin_n = 1'b1;
    logic clk_en, nop_o, cause_valid;
    logic [1:0] cause;

    always #2 clk = ~clk;

    stop_wake_ctrl #(.SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst(rst), .stop_req(stop_req), .stop_dis(stop_dis),
        .irq_mask(irq_mask), .nmi_mask(nmi_mask), .irq_n(irq_n), .nmi_n(nmi_n),
        .edge_pend(edge_pend), .rst_pin_n(rst_pin_n),
        .clk_en(clk_en), .nop_o(nop_o), .cause_valid(cause_valid), .cause(cause)
    );

    typedef struct {
        logic [1:0] code;
        int         start;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    bit   done  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: pops expected causes as the design reports them.
    always @(negedge clk) begin
        if (!rst && cause_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected cause", int'(cause), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cause == e.code, e.req, int'(cause), int'(e.code));
                check((cyc - e.start) == SETTLE + 3, "R4 latency", cyc - e.start, SETTLE + 3);
            end
        end
    end

    task automatic enter_stop(input logic im, input logic nm);
        @(negedge clk);
        irq_mask = im; nmi_mask = nm; stop_dis = 1'b0; stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check(clk_en == 1'b0, "R2 clk_en off", int'(clk_en), 0);
    endtask

    // Driver: applies pins at a negedge and queues the expected cause.
    task automatic wake(input logic r_n, input logic n_n, input logic i_n, input logic ep,
                        input logic [1:0] code, input string req);
        exp_t e;
        rst_pin_n = r_n; nmi_n = n_n; irq_n = i_n; edge_pend = ep;
        e.code = code; e.start = cyc; e.req = req;
        exp_q.push_back(e);
        repeat (SETTLE + 2) @(negedge clk);
        check(clk_en == 1'b0, "R4 settle off", int'(clk_en), 0);
        @(negedge clk);
        #1;
        check(clk_en == 1'b1 && cause_valid == 1'b1, "R10 enable with cause", int'(clk_en), 1);
        @(negedge clk);
        check(cause_valid == 1'b0 && clk_en == 1'b1, "R10 one cycle", int'(cause_valid), 0);
        rst_pin_n = 1'b1; nmi_n = 1'b1; irq_n = 1'b1; edge_pend = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(clk_en == 1'b1, "R1 clk_en", int'(clk_en), 1);
        check(cause_valid == 1'b0, "R1 cause_valid", int'(cause_valid), 0);
        check(nop_o == 1'b0, "R1 nop_o", int'(nop_o), 0);

        // R3 disabled stop acts as no-op
        stop_dis = 1'b1; stop_req = 1'b1;
        #1;
        check(nop_o == 1'b1, "R3 nop_o", int'(nop_o), 1);
        @(negedge clk);
        stop_req = 1'b0;
        check(clk_en == 1'b1, "R3 still running", int'(clk_en), 1);
        stop_dis = 1'b0;

        // R6 unmasked maskable pin
        enter_stop(1'b0, 1'b1);
        wake(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R6 irq cause");

        // R8 non-maskable pin, mask clear then set
        enter_stop(1'b1, 1'b0);
        wake(1'b1, 1'b0, 1'b1, 1'b0, 2'd1, "R8 nmi service");
        enter_stop(1'b1, 1'b1);
        wake(1'b1, 1'b0, 1'b1, 1'b0, 2'd2, "R8 nmi continue");

        // R5 masked pin holds stop; then nmi outranks the still-low irq (R9)
        enter_stop(1'b1, 1'b0);
        irq_n = 1'b0;
        repeat (12) @(negedge clk);
        check(clk_en == 1'b0, "R5 masked irq ignored", int'(clk_en), 0);
        // R11 stop request while stopped
        stop_dis = 1'b1; stop_req = 1'b1;
        #1;
        check(nop_o == 1'b0, "R11 no nop while stopped", int'(nop_o), 0);
        @(negedge clk);
        stop_req = 1'b0; stop_dis = 1'b0;
        check(clk_en == 1'b0, "R11 still stopped", int'(clk_en), 0);
        wake(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, "R9 nmi over irq");

        // R7 masked pending edge ignored, then reset pin exits
        enter_stop(1'b1, 1'b0);
        edge_pend = 1'b1;
        repeat (12) @(negedge clk);
        check(clk_en == 1'b0, "R7 masked edge ignored", int'(clk_en), 0);
        wake(1'b0, 1'b1, 1'b1, 1'b1, 2'd3, "R9 reset cause");

        // R7 unmasked pending edge
        enter_stop(1'b0, 1'b0);
        wake(1'b1, 1'b1, 1'b1, 1'b1, 2'd0, "R7 edge cause");

        // R9 all sources together: reset wins
        enter_stop(1'b0, 1'b0);
        wake(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, "R9 reset priority");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 all causes seen", exp_q.size(), 0);
        done = 1;
        report();
    end
endmodule